// File: doc/BRIEF.md
# EEPROM Pattern Write and Readback Sequencer

This block drives a byte-level serial-memory master through a simple command handshake and uses it to test a small EEPROM. It first stores a counting pattern: every location from 0 to `N_BYTES-1` gets a byte equal to the low eight bits of its own address. It then reads every location back in the same ascending order, using random (addressed) reads, and compares each returned byte with the pattern. The master's bit-level bus timing is handled elsewhere; this block only issues commands and judges the answers.

Each command is started by a one-cycle execute pulse. Its address, direction and write byte are held steady until the master answers with a one-cycle done pulse, which carries the read byte and a not-acknowledged flag. The command handshake is a plain request and completion pair: only one command is outstanding at a time, and the master throttles the block through the timing of its done pulse. After every write, the block leaves the memory a fixed settle time for its internal programming cycle before it issues anything else. Reads need no such pause. A not-acknowledged answer or a wrong read byte marks the run as failed, but the run still goes on to the last read. When it finishes, the block raises a sticky completion flag and a pass flag, and it drives an indicator lamp that stays lit on a pass and blinks on a failure.

The block runs on the master's operation clock, which is four times the serial clock rate. With a 1 MHz operation clock, the default settle time of 10000 cycles gives 10 ms. The default blink half-period of 125000 cycles gives a visible blink.

Top module: `ee_pattern_checker`

## Requirements
- R1: While reset is held low, `cmd_exec_o`, `test_done_o`, `test_pass_o` and `led_o` are all 0.
- R2: The write phase issues `N_BYTES` writes (`cmd_read_o` = 0) to addresses 0, 1, … `N_BYTES-1` in that order. Each write byte `cmd_wdata_o` equals the low eight bits of its address.
- R3: After the last write, the read phase issues `N_BYTES` reads (`cmd_read_o` = 1) to addresses 0 … `N_BYTES-1` in ascending order.
- R4: `cmd_exec_o` is high for exactly one cycle per command. `cmd_addr_o`, `cmd_read_o` and `cmd_wdata_o` do not change from the execute cycle until the done pulse arrives.
- R5: After the done pulse of any write, including the last one, the next execute pulse comes exactly `WAIT_CYCLES`+1 cycles after the done cycle, so at least `WAIT_CYCLES` cycles pass with no command.
- R6: After the done pulse of a read that is not the last, the next execute pulse comes in the very next cycle.
- R7: A read whose returned byte differs from the low eight bits of its address makes the final `test_pass_o` 0.
- R8: A done pulse that has `rsp_nack_i` = 1 (1 means not acknowledged, 0 means acknowledged), on a write or on a read, makes the final `test_pass_o` 0. Every remaining command is still issued.
- R9: `test_done_o` rises in the cycle after the done pulse of the last read and then stays high. From that cycle on, `test_pass_o` is 1 exactly when no mismatch and no not-acknowledged answer occurred.
- R10: After a passing run, `led_o` is 1 from the cycle after `test_done_o` rises and stays 1.
- R11: After a failing run, `led_o` is 0 for the first `BLINK_HALF` cycles in which `test_done_o` is high. It then inverts every `BLINK_HALF` cycles.
- R12: No execute pulse is issued once `test_done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock, four times the serial clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_exec_o | output | 1 | One-cycle pulse that starts a command |
| cmd_read_o | output | 1 | Command direction: 0 write, 1 read |
| cmd_addr_o | output | ADDR_W | Memory word address of the command |
| cmd_wdata_o | output | DATA_W | Byte to store, for writes |
| rsp_done_i | input | 1 | One-cycle pulse marking the end of the outstanding command |
| rsp_rdata_i | input | DATA_W | Byte returned by a read, valid with `rsp_done_i` |
| rsp_nack_i | input | 1 | Not-acknowledged flag, valid with `rsp_done_i` |
| test_done_o | output | 1 | Sticky flag: the whole sequence has finished |
| test_pass_o | output | 1 | Result flag, valid while `test_done_o` is high |
| led_o | output | 1 | Lamp: steady on for a pass, blinking for a failure |

## Verification
The bench counts clock edges and computes each expected cycle from the requirements. If a done pulse is seen at the edge that ends cycle j, the next execute pulse must appear in cycle j+`WAIT_CYCLES`+1 after a write and in cycle j+1 after a read. `test_done_o` must appear in cycle j+1 after the final read. With `test_done_o` first high in cycle d, the lamp is sampled at d+1 after a pass. After a failure it is sampled at d+B-1, d+B, d+2B-1 and d+2B. Every sample is taken at the falling edge, half a cycle away from the registers that produce it. The responder answers each command after a fixed latency, so each of these cycle numbers can be predicted.

// File: rtl/eeck_pkg.sv
package eeck_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_AWAIT,
    SQ_SETTLE,
    SQ_END
  } sq_state_t;

endpackage

// File: rtl/eeck_delay.sv
// Settle timer: while run_i is high it counts up, and expire_o is high in the
// CYCLES-th cycle of the run.
module eeck_delay #(
  parameter int unsigned CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CW'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || expire_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/eeck_cursor.sv
// Address cursor: walks the index through the write phase and then the read
// phase, moving one step per completed command.
module eeck_cursor #(
  parameter int unsigned N_BYTES = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_i,
  output logic [$clog2(N_BYTES)-1:0] idx_o,
  output logic                    rd_phase_o,
  output logic                    last_o
);
  localparam int unsigned IW = $clog2(N_BYTES);

  assign last_o = (idx_o == IW'(N_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_o      <= '0;
      rd_phase_o <= 1'b0;
    end else if (step_i) begin
      if (last_o) begin
        idx_o      <= '0;
        rd_phase_o <= 1'b1;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eeck_blinker.sv
// Lamp driver: off before the run ends, steady on for a pass, and a toggle
// every HALF cycles for a failure.
module eeck_blinker #(
  parameter int unsigned HALF = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic final_i,
  input  logic pass_i,
  output logic led_o
);
  localparam int unsigned HW = (HALF < 2) ? 1 : $clog2(HALF);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !final_i) begin
      cnt_q <= '0;
      led_o <= 1'b0;
    end else if (pass_i) begin
      cnt_q <= '0;
      led_o <= 1'b1;
    end else if (cnt_q == HW'(HALF - 1)) begin
      cnt_q <= '0;
      led_o <= ~led_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ee_pattern_checker.sv
module ee_pattern_checker #(
  parameter int unsigned N_BYTES     = 256,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WAIT_CYCLES = 10000,
  parameter int unsigned BLINK_HALF  = 125000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cmd_exec_o,
  output logic              cmd_read_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  input  logic              rsp_done_i,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  input  logic              rsp_nack_i,
  output logic              test_done_o,
  output logic              test_pass_o,
  output logic              led_o
);
  import eeck_pkg::*;

  localparam int unsigned IW = $clog2(N_BYTES);

  sq_state_t      st_q;
  logic [IW-1:0]  idx;
  logic           rd_phase;
  logic           at_last;
  logic           step;
  logic           settle_over;
  logic           fail_q;
  logic [DATA_W-1:0] pattern;

  assign step    = (st_q == SQ_AWAIT) && rsp_done_i;
  assign pattern = DATA_W'(idx);

  eeck_cursor #(.N_BYTES(N_BYTES)) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step),
    .idx_o     (idx),
    .rd_phase_o(rd_phase),
    .last_o    (at_last)
  );

  eeck_delay #(.CYCLES(WAIT_CYCLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (st_q == SQ_SETTLE),
    .expire_o(settle_over)
  );

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
    end else begin
      unique case (st_q)
        SQ_IDLE:   st_q <= SQ_ISSUE;
        SQ_ISSUE:  st_q <= SQ_AWAIT;
        SQ_AWAIT: begin
          if (rsp_done_i) begin
            if (!rd_phase)    st_q <= SQ_SETTLE;
            else if (at_last) st_q <= SQ_END;
            else              st_q <= SQ_ISSUE;
          end
        end
        SQ_SETTLE: if (settle_over) st_q <= SQ_ISSUE;
        SQ_END:    st_q <= SQ_END;
        default:   st_q <= SQ_IDLE;
      endcase
    end
  end

  // verdict: any refusal or any wrong byte is remembered
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
    end else if (step) begin
      if (rsp_nack_i || (rd_phase && (rsp_rdata_i != pattern))) begin
        fail_q <= 1'b1;
      end
    end
  end

  assign cmd_exec_o  = (st_q == SQ_ISSUE);
  assign cmd_read_o  = rd_phase;
  assign cmd_addr_o  = ADDR_W'(idx);
  assign cmd_wdata_o = pattern;
  assign test_done_o = (st_q == SQ_END);
  assign test_pass_o = test_done_o && !fail_q;

  eeck_blinker #(.HALF(BLINK_HALF)) u_lamp (
    .clk    (clk),
    .rst_n  (rst_n),
    .final_i(test_done_o),
    .pass_i (test_pass_o),
    .led_o  (led_o)
  );
endmodule

// File: rtl/ee_pattern_checker_sva.sv
module ee_pattern_checker_sva #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WAIT_CYCLES = 10000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_exec_o,
  input logic              cmd_read_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [DATA_W-1:0] cmd_wdata_o,
  input logic              rsp_done_i,
  input logic              test_done_o,
  input logic              test_pass_o,
  input logic              led_o
);
  localparam int unsigned GW = $clog2(WAIT_CYCLES + 2);

  logic          busy_q;
  logic          cur_wr_q;
  logic          settle_due_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      cur_wr_q     <= 1'b0;
      settle_due_q <= 1'b0;
      gap_q        <= '0;
    end else begin
      if (cmd_exec_o) begin
        busy_q       <= 1'b1;
        cur_wr_q     <= !cmd_read_o;
        settle_due_q <= 1'b0;
      end else if (rsp_done_i) begin
        busy_q <= 1'b0;
      end
      if (rsp_done_i && busy_q && cur_wr_q) begin
        gap_q        <= '0;
        settle_due_q <= 1'b1;
      end else if (gap_q < GW'(WAIT_CYCLES)) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  AST_EXEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_exec_o |=> !cmd_exec_o); // R4

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_exec_o || busy_q) && !rsp_done_i |=>
      $stable(cmd_addr_o) && $stable(cmd_read_o) && $stable(cmd_wdata_o)); // R4

  AST_WR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_exec_o && !cmd_read_o |-> cmd_wdata_o == cmd_addr_o[7:0]); // R2

  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_exec_o && settle_due_q |-> gap_q >= GW'(WAIT_CYCLES)); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    test_done_o |=> test_done_o); // R9

  AST_PASS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    test_pass_o |-> test_done_o); // R9

  AST_QUIET_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    test_done_o |-> !cmd_exec_o); // R12

  AST_LED_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    test_done_o && test_pass_o |=> led_o); // R10
endmodule

bind ee_pattern_checker ee_pattern_checker_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_CYCLES(WAIT_CYCLES)
) u_sva (
  .clk(clk), .rst_n(rst_n), .cmd_exec_o(cmd_exec_o), .cmd_read_o(cmd_read_o),
  .cmd_addr_o(cmd_addr_o), .cmd_wdata_o(cmd_wdata_o), .rsp_done_i(rsp_done_i),
  .test_done_o(test_done_o), .test_pass_o(test_pass_o), .led_o(led_o)
);

// File: tb/sim_ee_pattern_checker.sv
`timescale 1ns/1ps
module sim_ee_pattern_checker;
  localparam int N   = 256;
  localparam int W   = 12;
  localparam int B   = 10;
  localparam int LAT = 3;

  typedef struct { bit rd; int addr; } exp_cmd_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_exec_o, cmd_read_o, test_done_o, test_pass_o, led_o;
  logic [15:0] cmd_addr_o;
  logic [7:0]  cmd_wdata_o;
  logic        rsp_done_i = 1'b0;
  logic [7:0]  rsp_rdata_i = '0;
  logic        rsp_nack_i = 1'b0;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  exp_cmd_t exp_q[$];
  logic [7:0] mem [N];
  int  corrupt_at, nack_w_at, nack_r_at;
  int  prev_done_cyc;
  bit  prev_was_wr;
  bit  have_prev;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ee_pattern_checker #(
    .N_BYTES(N), .ADDR_W(16), .DATA_W(8), .WAIT_CYCLES(W), .BLINK_HALF(B)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_exec_o(cmd_exec_o), .cmd_read_o(cmd_read_o),
    .cmd_addr_o(cmd_addr_o), .cmd_wdata_o(cmd_wdata_o), .rsp_done_i(rsp_done_i),
    .rsp_rdata_i(rsp_rdata_i), .rsp_nack_i(rsp_nack_i), .test_done_o(test_done_o),
    .test_pass_o(test_pass_o), .led_o(led_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: lists the commands the requirements call for
  task automatic push_expected();
    exp_q.delete();
    for (int i = 0; i < N; i++) exp_q.push_back('{rd: 1'b0, addr: i}); // R2
    for (int i = 0; i < N; i++) exp_q.push_back('{rd: 1'b1, addr: i}); // R3
  endtask

  // monitor and memory responder
  task automatic serve();
    exp_cmd_t e;
    int       a;
    bit       rd;
    int       now;
    now = cyc;
    rd  = cmd_read_o;
    a   = int'(cmd_addr_o);
    if (exp_q.size() == 0) begin
      chk("R12 exec after sequence end", 1, 0);
    end else begin
      e = exp_q.pop_front();
      chk(e.rd ? "R3 direction" : "R2 direction", int'(rd), int'(e.rd));
      chk(e.rd ? "R3 address" : "R2 address", a, e.addr);
      if (!e.rd) chk("R2 write byte", int'(cmd_wdata_o), e.addr & 8'hFF);
    end
    if (have_prev) begin
      if (prev_was_wr) chk("R5 settle gap", now - prev_done_cyc, W + 1);
      else             chk("R6 read-to-read gap", now - prev_done_cyc, 1);
    end
    @(negedge clk);
    chk("R4 exec width", int'(cmd_exec_o), 0);
    repeat (LAT - 1) @(negedge clk);
    chk("R4 address held", int'(cmd_addr_o), a);
    rsp_done_i  = 1'b1;
    rsp_rdata_i = rd ? mem[a % N] : 8'h00;
    rsp_nack_i  = rd ? (a == nack_r_at) : (a == nack_w_at);
    if (!rd) mem[a % N] = (a == corrupt_at) ? (cmd_wdata_o ^ 8'h01) : cmd_wdata_o;
    prev_done_cyc = cyc;
    prev_was_wr   = !rd;
    have_prev     = 1'b1;
    @(negedge clk);
    rsp_done_i  = 1'b0;
    rsp_nack_i  = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (rst_n && cmd_exec_o) serve();
    end
  end

  task automatic run(input string tag, input int ca, input int nw, input int nr,
                     input bit exp_pass);
    int d;
    int guard;
    rst_n = 1'b0;
    corrupt_at = ca; nack_w_at = nw; nack_r_at = nr;
    have_prev = 1'b0;
    for (int i = 0; i < N; i++) mem[i] = 8'hEE;
    push_expected();
    repeat (3) @(negedge clk);
    chk("R1 exec in reset", int'(cmd_exec_o), 0);
    chk("R1 done in reset", int'(test_done_o), 0);
    chk("R1 pass in reset", int'(test_pass_o), 0);
    chk("R1 led in reset", int'(led_o), 0);
    rst_n = 1'b1;
    guard = 0;
    while (!test_done_o && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    d = cyc;
    $display("[TB] scenario %s finished at cycle %0d", tag, d);
    chk("R9 done reached", int'(test_done_o), 1);
    chk("R8 all commands issued", exp_q.size(), 0);
    chk("R9 done timing", d - prev_done_cyc, 1);
    chk("R7 R8 R9 verdict", int'(test_pass_o), int'(exp_pass));
    if (exp_pass) begin
      @(negedge clk);
      chk("R10 lamp on", int'(led_o), 1);
      repeat (3 * B) @(negedge clk);
      chk("R10 lamp steady", int'(led_o), 1);
    end else begin
      repeat (B - 1) @(negedge clk);
      chk("R11 lamp dark first half", int'(led_o), 0);
      @(negedge clk);
      chk("R11 lamp first toggle", int'(led_o), 1);
      repeat (B - 1) @(negedge clk);
      chk("R11 lamp holds half", int'(led_o), 1);
      @(negedge clk);
      chk("R11 lamp second toggle", int'(led_o), 0);
    end
    chk("R9 done sticky", int'(test_done_o), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    run("clean",       -1, -1, -1, 1'b1);
    run("bad_byte",    77, -1, -1, 1'b0); // R7
    run("nack_write",  -1,  5, -1, 1'b0); // R8
    run("nack_read",   -1, -1, 200, 1'b0); // R8
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule